// File: doc/BRIEF.md
# AVI Infoframe Packet Builder

This block builds the auxiliary video information packet that a display transmitter inserts into the blanking interval. The packet has three header bytes, one checksum byte and thirteen payload bytes. The header carries a packet type of 0x82, formed from the infoframe flag 0x80 and the AVI code 0x02. It also carries version 2 and the payload length of 13. The payload fields for colour space, underscan, active-format presence, picture aspect, active format ratio and video identification code come from configuration inputs. The checksum is computed in hardware so that the whole packet sums to zero.

Bytes leave on a byte-wide valid/ready stream, and a last flag marks the final payload byte. A two-bit transmit mode chooses the send policy. Mode 0 is off, mode 1 sends once, mode 2 sends on every vertical sync, and mode 3 is reserved and behaves as off. A packet starts on a rising edge of the vertical sync input. The configuration is captured when the packet starts. While a packet is streaming, further sync edges are dropped.

Top module: `avi_pkt_builder`

## Requirements
- R1: After reset, valid_o and last_o are low, and no byte is presented until a trigger starts a packet.
- R2: A packet is exactly 17 bytes in this order: 0x82, 0x02, 0x0D, checksum, then payload bytes 1 to 13. last_o is high only with payload byte 13.
- R3: The 17 bytes of a packet add to 0 modulo 256. The checksum therefore equals (0x100 - (sum of the other 16 bytes & 0xFF)) truncated to 8 bits.
- R4: Payload byte 1 has underscan_i in bit 1, afd_present_i in bit 4 and colour_i in bits 6:5 (0 = RGB). All its other bits are 0.
- R5: Payload byte 2 has aspect_i in bits 5:4 (2 = 16:9) and afr_i in bits 3:0 (8 = same as picture), with bits 7:6 zero. A 16:9 picture whose active format equals the picture therefore gives 0x28.
- R6: Payload byte 4 has vic_i in bits 6:0 and bit 7 zero (1920x1080 at 60 Hz is code 16). Payload bytes 3 and 5 to 13 are 0.
- R7: With tx_mode_i at 0 (off) or 3 (reserved), a rising edge of vsync_i starts no packet.
- R8: With tx_mode_i at 2, every rising edge of vsync_i that finds the block idle starts a packet. valid_o goes high in the cycle after the clock edge that samples vsync_i high for the first time.
- R9: With tx_mode_i at 1, only the first rising edge after the mode becomes 1 starts a packet. Later edges are ignored until tx_mode_i leaves 1 and returns.
- R10: A rising edge of vsync_i while a packet is streaming neither restarts the packet nor queues another one.
- R11: While valid_o is high and ready_i is low, data_o, last_o and valid_o hold. The stream advances by one byte only on a valid/ready handshake.
- R12: The configuration inputs are captured in the cycle a packet starts. Changes to them during streaming do not alter that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_mode_i | input | 2 | Send policy: 0 off, 1 once, 2 every vsync, 3 reserved (off) |
| vsync_i | input | 1 | Vertical sync; its rising edge is the trigger |
| underscan_i | input | 1 | Underscanned display flag |
| afd_present_i | input | 1 | Active format information present |
| colour_i | input | 2 | Colour space code (0 = RGB) |
| aspect_i | input | 2 | Picture aspect code |
| afr_i | input | 4 | Active format aspect ratio code |
| vic_i | input | 7 | Video identification code |
| data_o | output | 8 | Packet byte |
| valid_o | output | 1 | data_o holds a packet byte |
| last_o | output | 1 | Final byte of the packet |
| ready_i | input | 1 | Sink accepts data_o this cycle |

## Verification
A vsync rise that the bench drives at a falling edge is sampled at the next rising edge. The header type byte is on data_o one cycle later. The bench therefore checks the first byte at the falling edge right after it lowers vsync_i. Each later byte is due one cycle after the handshake on the previous byte. The bench samples data_o, valid_o and last_o at falling edges and counts a byte as accepted only when it drove ready_i high before that edge. Stall cycles therefore show the held byte, and the expected stream advances only on a handshake. Quiet periods are checked for a full packet length plus margin after each trigger that must be ignored.

// File: rtl/avi_pkt_pkg.sv
package avi_pkt_pkg;

  typedef enum logic [1:0] {
    TX_OFF   = 2'd0,
    TX_ONCE  = 2'd1,
    TX_EVERY = 2'd2,
    TX_RSV   = 2'd3
  } tx_mode_e;

  typedef struct packed {
    logic       underscan;
    logic       afd_present;
    logic [1:0] colour;
    logic [1:0] aspect;
    logic [3:0] afr;
    logic [6:0] vic;
  } avi_cfg_t;

  localparam int unsigned HDR_LEN = 3;

endpackage

// File: rtl/avi_field_pack.sv
module avi_field_pack
  import avi_pkt_pkg::*;
#(
  parameter int unsigned PAYLOAD_LEN = 13
) (
  input  avi_cfg_t                      cfg_i,
  output logic [PAYLOAD_LEN-1:0][7:0]   payload_o
);

  always_comb begin
    for (int i = 0; i < PAYLOAD_LEN; i++) payload_o[i] = 8'h00;
    // byte 1: scan, format-present, colour space
    payload_o[0] = {1'b0, cfg_i.colour, cfg_i.afd_present, 2'b00, cfg_i.underscan, 1'b0};
    // byte 2: picture aspect, active format ratio
    payload_o[1] = {2'b00, cfg_i.aspect, cfg_i.afr};
    // byte 4: video code
    payload_o[3] = {1'b0, cfg_i.vic};
  end

endmodule

// File: rtl/avi_csum.sv
module avi_csum
  import avi_pkt_pkg::*;
#(
  parameter int unsigned PAYLOAD_LEN = 13
) (
  input  logic [HDR_LEN-1:0][7:0]     hdr_i,
  input  logic [PAYLOAD_LEN-1:0][7:0] payload_i,
  output logic [7:0]                  csum_o
);

  logic [7:0] acc;

  always_comb begin
    acc = 8'h00;
    for (int i = 0; i < HDR_LEN; i++)     acc = acc + hdr_i[i];
    for (int i = 0; i < PAYLOAD_LEN; i++) acc = acc + payload_i[i];
    csum_o = 8'h00 - acc;
  end

endmodule

// File: rtl/avi_sched.sv
module avi_sched
  import avi_pkt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] tx_mode_i,
  input  logic       vsync_i,
  input  logic       busy_i,
  output logic       start_o
);

  logic vs_q;
  logic armed_q;
  logic vs_rise;
  logic eligible;

  assign vs_rise  = vsync_i & ~vs_q;
  assign eligible = (tx_mode_i == TX_EVERY) || ((tx_mode_i == TX_ONCE) && armed_q);
  assign start_o  = vs_rise & eligible & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q    <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      vs_q <= vsync_i;
      if (tx_mode_i != TX_ONCE) armed_q <= 1'b1;
      else if (start_o)         armed_q <= 1'b0;
    end
  end

  // R9: once mode fires a single time until re-armed
  a_r9_once_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o && (tx_mode_i == TX_ONCE) |=> !start_o || (tx_mode_i != TX_ONCE));

  // R7: off and reserved modes never start a packet
  a_r7_no_start_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tx_mode_i == TX_OFF) || (tx_mode_i == TX_RSV)) |-> !start_o);

endmodule

// File: rtl/avi_pkt_builder.sv
module avi_pkt_builder
  import avi_pkt_pkg::*;
#(
  parameter int unsigned PAYLOAD_LEN = 13,
  parameter logic [7:0]  TYPE_CODE   = 8'h82,
  parameter logic [7:0]  VERSION     = 8'h02
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] tx_mode_i,
  input  logic       vsync_i,
  input  logic       underscan_i,
  input  logic       afd_present_i,
  input  logic [1:0] colour_i,
  input  logic [1:0] aspect_i,
  input  logic [3:0] afr_i,
  input  logic [6:0] vic_i,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       last_o,
  input  logic       ready_i
);

  localparam int unsigned PKT_LEN = HDR_LEN + 1 + PAYLOAD_LEN;
  localparam int unsigned IDX_W   = $clog2(PKT_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);

  avi_cfg_t                    cfg_in, snap_q;
  logic [HDR_LEN-1:0][7:0]     hdr;
  logic [PAYLOAD_LEN-1:0][7:0] payload;
  logic [7:0]                  csum;
  logic                        busy_q, start;
  logic [IDX_W-1:0]            idx_q;
  logic                        xfer;

  assign cfg_in = '{underscan:   underscan_i,
                    afd_present: afd_present_i,
                    colour:      colour_i,
                    aspect:      aspect_i,
                    afr:         afr_i,
                    vic:         vic_i};

  assign hdr[0] = TYPE_CODE;
  assign hdr[1] = VERSION;
  assign hdr[2] = 8'(PAYLOAD_LEN);

  avi_sched u_sched (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_mode_i (tx_mode_i),
    .vsync_i   (vsync_i),
    .busy_i    (busy_q),
    .start_o   (start)
  );

  avi_field_pack #(.PAYLOAD_LEN(PAYLOAD_LEN)) u_pack (
    .cfg_i     (snap_q),
    .payload_o (payload)
  );

  avi_csum #(.PAYLOAD_LEN(PAYLOAD_LEN)) u_csum (
    .hdr_i     (hdr),
    .payload_i (payload),
    .csum_o    (csum)
  );

  assign xfer = busy_q & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      snap_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      snap_q <= cfg_in;
    end else if (xfer) begin
      if (idx_q == LAST_IDX) busy_q <= 1'b0;
      else                   idx_q  <= idx_q + 1'b1;
    end
  end

  always_comb begin
    data_o = 8'h00;
    for (int i = 0; i < HDR_LEN; i++)
      if (idx_q == IDX_W'(i)) data_o = hdr[i];
    if (idx_q == IDX_W'(HDR_LEN)) data_o = csum;
    for (int i = 0; i < PAYLOAD_LEN; i++)
      if (idx_q == IDX_W'(HDR_LEN + 1 + i)) data_o = payload[i];
  end

  assign valid_o = busy_q;
  assign last_o  = busy_q && (idx_q == LAST_IDX);

  // R2: last only accompanies a valid byte
  a_r2_last_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  // R8: a packet always opens with the type byte
  a_r8_first_is_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> data_o == TYPE_CODE);

  // R11: stalled byte holds
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(last_o));

  // R10: streaming is not cut short or restarted
  a_r10_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !(ready_i && last_o) |=> valid_o);

  // R12: captured configuration is frozen mid-packet
  a_r12_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !(ready_i && last_o) |=> $stable(snap_q));

  // R7: idle output stays idle in off/reserved modes
  a_r7_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && ((tx_mode_i == TX_OFF) || (tx_mode_i == TX_RSV)) |=> !valid_o);

endmodule

// File: tb/avi_pkt_builder_tb.sv
module avi_pkt_builder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PKT_BYTES  = 17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] tx_mode = 2'd0;
  logic       vsync = 1'b0;
  logic       us = 1'b0, afd = 1'b0;
  logic [1:0] col = '0, asp = '0;
  logic [3:0] afr = '0;
  logic [6:0] vic = '0;
  logic [7:0] data;
  logic       valid, last;
  logic       ready = 1'b1;

  // expected configuration
  int e_us, e_afd, e_col, e_asp, e_afr, e_vic;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  avi_pkt_builder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_mode_i(tx_mode), .vsync_i(vsync),
    .underscan_i(us), .afd_present_i(afd), .colour_i(col), .aspect_i(asp),
    .afr_i(afr), .vic_i(vic), .data_o(data), .valid_o(valid), .last_o(last),
    .ready_i(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_byte(input int idx);
    int pb1, pb2, pb4, s;
    pb1 = e_us * 2 + e_afd * 16 + e_col * 32;
    pb2 = e_asp * 16 + e_afr;
    pb4 = e_vic;
    s   = 8'h82 + 2 + 13 + pb1 + pb2 + pb4;
    case (idx)
      0: return 8'h82;
      1: return 2;
      2: return 13;
      3: return (256 - (s % 256)) % 256;
      4: return pb1;
      5: return pb2;
      7: return pb4;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int idx);
    if (idx == 3) return "R3";
    if (idx < 4)  return "R2";
    if (idx == 4) return "R4";
    if (idx == 5) return "R5";
    return "R6";
  endfunction

  task automatic set_cfg(input int u, input int a, input int c, input int p,
                         input int r, input int v);
    e_us = u; e_afd = a; e_col = c; e_asp = p; e_afr = r; e_vic = v;
    us = u[0]; afd = a[0]; col = c[1:0]; asp = p[1:0]; afr = r[3:0]; vic = v[6:0];
  endtask

  task automatic vs_pulse();
    @(negedge clk) vsync = 1'b1;
    @(negedge clk) vsync = 1'b0;
  endtask

  // Call right after vs_pulse: checks a full packet at falling edges.
  task automatic collect(input bit stall, input bit mid_vs, input bit mid_cfg);
    int got = 0, sum = 0, cyc = 0;
    bit done = 0, held_ok = 1;
    int prev_d = -1;
    bit prev_stall = 0;
    chk(valid === 1'b1, "R8 valid after trigger", int'(valid), 1);
    chk(data == 8'h82, "R8 first byte", int'(data), 8'h82);
    while (!done && cyc < 80) begin
      if (prev_stall && valid && prev_d != int'(data)) held_ok = 0;
      ready = stall ? (cyc % 3 != 1) : 1'b1;
      if (mid_vs && cyc == 4) vsync = 1'b1;
      if (mid_vs && cyc == 5) vsync = 1'b0;
      if (mid_cfg && cyc == 3) begin
        us = ~us; afd = ~afd; col = col + 1; asp = asp + 1; afr = afr + 3; vic = vic + 9;
      end
      if (valid && ready) begin
        chk(int'(data) == exp_byte(got), tag_of(got), int'(data), exp_byte(got));
        chk(last == (got == PKT_BYTES - 1), "R2 last flag", int'(last), int'(got == PKT_BYTES - 1));
        sum += int'(data);
        got++;
        if (last) done = 1;
      end
      prev_stall = valid && !ready;
      prev_d = int'(data);
      @(negedge clk);
      cyc++;
    end
    ready = 1'b1;
    chk(got == PKT_BYTES, "R2 byte count", got, PKT_BYTES);
    chk(sum % 256 == 0, "R3 packet sum", sum % 256, 0);
    if (stall) chk(held_ok, "R11 stalled byte held", int'(held_ok), 1);
    // restore inputs for next test
    set_cfg(e_us, e_afd, e_col, e_asp, e_afr, e_vic);
  endtask

  task automatic expect_quiet(input int n, input string req);
    bit q = 1;
    for (int i = 0; i < n; i++) begin
      if (valid !== 1'b0) q = 0;
      @(negedge clk);
    end
    chk(q, req, int'(!q), 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    set_cfg(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(valid === 1'b0, "R1 valid in reset", int'(valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid === 1'b0 && last === 1'b0, "R1 idle after reset", int'({valid, last}), 0);
    expect_quiet(10, "R1 no packet without trigger");

    // R7: off and reserved
    tx_mode = 2'd0; vs_pulse(); expect_quiet(25, "R7 mode off quiet");
    tx_mode = 2'd3; vs_pulse(); expect_quiet(25, "R7 mode reserved quiet");

    // R5/R6 nominal 1080p60 16:9 case: PB2 0x28, VIC 16
    tx_mode = 2'd2;
    set_cfg(1, 1, 0, 2, 8, 16);
    vs_pulse(); collect(0, 0, 0);
    chk(exp_byte(5) == 8'h28, "R5 16:9 byte", exp_byte(5), 8'h28);

    // R4..R6, R8: sweep of field combinations in every-vsync mode
    for (int i = 0; i < 64; i++) begin
      set_cfg(i & 1, (i >> 1) & 1, (i >> 2) & 3, (i >> 4) & 3, (i * 5) & 15, (i * 37 + 1) & 127);
      vs_pulse();
      collect(i[0], 0, 0);
      @(negedge clk);
    end

    // R10: vsync during streaming ignored, not queued
    set_cfg(0, 1, 1, 1, 9, 97);
    vs_pulse(); collect(0, 1, 0);
    expect_quiet(25, "R10 no queued packet");

    // R12: config changes mid-packet do not alter it
    set_cfg(1, 0, 2, 2, 10, 4);
    vs_pulse(); collect(1, 0, 1);

    // R9: once mode
    tx_mode = 2'd1;
    set_cfg(1, 1, 0, 2, 8, 16);
    vs_pulse(); collect(0, 0, 0);
    vs_pulse(); expect_quiet(25, "R9 second edge ignored in once mode");
    tx_mode = 2'd0; @(negedge clk); tx_mode = 2'd1;
    vs_pulse(); collect(0, 0, 0);
    vs_pulse(); expect_quiet(25, "R9 ignored after re-arm packet");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule